// File: doc/BRIEF.md
# Four-Port Byte-Lane Synchronous SRAM

This block is a word-organised static memory that four requesters share at the same time. Each word holds two 9-bit byte lanes. Every port has its own address, write data, read data, lane selects, a pair of chip enables of opposite polarity, a read/write strobe and an output enable. A port takes part in a clock edge only when its chip enables agree and its clock strobe is high. Writes update only the lanes the port selects. Reads go through a per-port output register. The output enable then gates each lane's valid flag and data without waiting for a clock.

All ports run on one core clock. A port whose clock is gated drives its strobe low and holds its state. When several ports write the same word on the same edge, the lowest-numbered port wins on each lane. The address width is a parameter: the full configuration uses 16 bits (64K words), and the default elaboration uses a smaller array. One asynchronous active-low reset clears every port's output stage and blocks writes while it is low. The stored contents are kept through reset.

Top module: `quad_sram`

## Requirements
- R1: A port is active on an edge only when its strobe `port_clk_en` is 1, `port_ce0_n` is 0 and `port_ce1` is 1. An edge where the strobe is high but the port is not selected writes nothing and clears that port's valid flags.
- R2: With `port_we_n` = 0 on an active edge, the word at `port_addr` is written lane by lane. Lane select bit 0 (active low) guards data bits 8:0 and bit 1 guards bits 17:9. A lane whose select is 1 keeps its old contents.
- R3: With `port_we_n` = 1 on an active edge, the word at `port_addr` is captured into the port's output register and is visible after that edge. Only lanes whose select was 0 at the edge are marked. The next active edge that is not a read clears the marks.
- R4: `port_rvalid` bit l equals the captured mark for lane l while `port_oe_n` is 0. This acts combinationally, with no clock edge. A lane whose valid bit is 0 reads as all zeros on `port_rdata`.
- R5: When several ports write the same word on the same edge, each lane takes the data of the lowest-numbered port that writes that lane.
- R6: A read on the same edge as a write to the same word, by any port, returns the contents from before that edge.
- R7: While `rst_n` is 0, every `port_rvalid` and `port_rdata` reads 0 at once, without a clock edge, and no write takes effect. Stored words are unchanged by reset.
- R8: On an edge where a port's strobe is 0, that port writes nothing and its output register holds its previous marks and data.
- R9: All four ports can read different words on the same edge, and each gets its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock shared by all ports |
| rst_n | input | 1 | Asynchronous active-low master reset |
| port_clk_en | input | PORTS | Per-port clock strobe; 0 gates the port for that edge |
| port_ce0_n | input | PORTS | First chip enable, active low |
| port_ce1 | input | PORTS | Second chip enable, active high |
| port_we_n | input | PORTS | 0 = write, 1 = read |
| port_oe_n | input | PORTS | Output enable, active low, combinational |
| port_lane_n | input | PORTS x LANES | Byte-lane selects, active low, bit 0 = lower lane |
| port_addr | input | PORTS x ADDR_W | Word address per port |
| port_wdata | input | PORTS x 18 | Write data per port |
| port_rdata | output | PORTS x 18 | Read data per port, zero on lanes that are not valid |
| port_rvalid | output | PORTS x LANES | Per-lane read-valid flags |

## Verification
A corrupted word or a wrong lane mask stays hidden until some port reads that word. The bench therefore fills the whole small array and then reads every word back through every port with rotating lane and output-enable patterns. This exposes wrong storage within one cycle of the read. A wrong priority between colliding writers shows up on the read that follows the collision. A wrong hold or clear in an output register changes `port_rvalid` on the very next edge. The output-enable and reset paths are checked between clock edges, where any registered shortcut would show a stale value.

// File: rtl/quad_sram_pkg.sv
package quad_sram_pkg;

    localparam int DEF_PORTS  = 4;
    localparam int DEF_ADDR_W = 8;
    localparam int DEF_LANE_W = 9;
    localparam int DEF_LANES  = 2;

    // What a port does on the coming edge
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,   // strobed but not selected
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_HOLD  = 2'd3    // clock strobe low: port frozen
    } acc_e;

endpackage

// File: rtl/quad_sram_decode.sv
module quad_sram_decode
    import quad_sram_pkg::*;
#(
    parameter int LANES = DEF_LANES
) (
    input  logic             clk_en,
    input  logic             ce0_n,
    input  logic             ce1,
    input  logic             we_n,
    input  logic [LANES-1:0] lane_n,
    output acc_e             acc,
    output logic [LANES-1:0] lane_sel,
    output logic [LANES-1:0] wr_lane
);

    always_comb begin
        lane_sel = ~lane_n;
        if (!clk_en) begin
            acc = ACC_HOLD;
        end else if (ce0_n || !ce1) begin
            acc = ACC_IDLE;
        end else if (we_n) begin
            acc = ACC_READ;
        end else begin
            acc = ACC_WRITE;
        end
        wr_lane = (acc == ACC_WRITE) ? lane_sel : '0;
    end

endmodule

// File: rtl/quad_sram_rdport.sv
module quad_sram_rdport
    import quad_sram_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_e              acc,
    input  logic [LANES-1:0]  lane_sel,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] mem_word,
    output logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  rvalid
);

    typedef struct packed {
        logic [LANES-1:0]  lane;
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (acc)
            ACC_READ: begin
                st_d.lane = lane_sel;
                st_d.data = mem_word;
            end
            ACC_HOLD: st_d = st_q;
            default:  st_d.lane = '0;
        endcase

        // output enable is applied without a clock
        rvalid = st_q.lane & {LANES{~oe_n}};
        rdata  = '0;
        for (int l = 0; l < LANES; l++) begin
            if (rvalid[l]) begin
                rdata[l*LANE_W +: LANE_W] = st_q.data[l*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_GATED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        acc == ACC_HOLD |=> $stable(st_q)); // R8

    AST_NONREAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_IDLE || acc == ACC_WRITE) |=> st_q.lane == '0); // R3

endmodule

// File: rtl/quad_sram_array.sv
module quad_sram_array
    import quad_sram_pkg::*;
#(
    parameter int PORTS  = DEF_PORTS,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANE_W = DEF_LANE_W,
    parameter int LANES  = DEF_LANES,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PORTS-1:0][ADDR_W-1:0]  addr,
    input  logic [PORTS-1:0][DATA_W-1:0]  wdata,
    input  logic [PORTS-1:0][LANES-1:0]   wr_lane,
    output logic [PORTS-1:0][DATA_W-1:0]  rd_word
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    // Highest port applied first so the lowest-numbered writer lands last
    always_comb begin
        mem_d = mem_q;
        if (rst_n) begin
            for (int p = PORTS - 1; p >= 0; p--) begin
                for (int l = 0; l < LANES; l++) begin
                    if (wr_lane[p][l]) begin
                        mem_d[addr[p]][l*LANE_W +: LANE_W] = wdata[p][l*LANE_W +: LANE_W];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    // Pre-edge contents feed every port's output register
    always_comb begin
        for (int p = 0; p < PORTS; p++) begin
            rd_word[p] = mem_q[addr[p]];
        end
    end

    logic touch0;
    always_comb begin
        touch0 = 1'b0;
        for (int p = 0; p < PORTS; p++) begin
            if ((wr_lane[p] != '0) && (addr[p] == '0)) begin
                touch0 = 1'b1;
            end
        end
    end

    AST_WORD0_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !touch0 |=> $stable(mem_q[0])); // R2

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        AST_TOP_PORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            wr_lane[0][l] |=> mem_q[$past(addr[0])][l*LANE_W +: LANE_W]
                              == $past(wdata[0][l*LANE_W +: LANE_W])); // R5
    end

endmodule

// File: rtl/quad_sram.sv
module quad_sram
    import quad_sram_pkg::*;
#(
    parameter int PORTS  = DEF_PORTS,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANE_W = DEF_LANE_W,
    parameter int LANES  = DEF_LANES,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PORTS-1:0]              port_clk_en,
    input  logic [PORTS-1:0]              port_ce0_n,
    input  logic [PORTS-1:0]              port_ce1,
    input  logic [PORTS-1:0]              port_we_n,
    input  logic [PORTS-1:0]              port_oe_n,
    input  logic [PORTS-1:0][LANES-1:0]   port_lane_n,
    input  logic [PORTS-1:0][ADDR_W-1:0]  port_addr,
    input  logic [PORTS-1:0][DATA_W-1:0]  port_wdata,
    output logic [PORTS-1:0][DATA_W-1:0]  port_rdata,
    output logic [PORTS-1:0][LANES-1:0]   port_rvalid
);

    acc_e                         acc      [PORTS];
    logic [PORTS-1:0][LANES-1:0]  lane_sel;
    logic [PORTS-1:0][LANES-1:0]  wr_lane;
    logic [PORTS-1:0][DATA_W-1:0] rd_word;

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        quad_sram_decode #(
            .LANES (LANES)
        ) u_decode (
            .clk_en   (port_clk_en[p]),
            .ce0_n    (port_ce0_n[p]),
            .ce1      (port_ce1[p]),
            .we_n     (port_we_n[p]),
            .lane_n   (port_lane_n[p]),
            .acc      (acc[p]),
            .lane_sel (lane_sel[p]),
            .wr_lane  (wr_lane[p])
        );

        quad_sram_rdport #(
            .LANES  (LANES),
            .LANE_W (LANE_W)
        ) u_rdport (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc      (acc[p]),
            .lane_sel (lane_sel[p]),
            .oe_n     (port_oe_n[p]),
            .mem_word (rd_word[p]),
            .rdata    (port_rdata[p]),
            .rvalid   (port_rvalid[p])
        );
    end

    quad_sram_array #(
        .PORTS  (PORTS),
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (port_addr),
        .wdata   (port_wdata),
        .wr_lane (wr_lane),
        .rd_word (rd_word)
    );

endmodule

// File: tb/quad_sram_bench.sv
`timescale 1ns/1ps
module quad_sram_bench;

    localparam int NP = 4;
    localparam int AW = 4;
    localparam int NW = 1 << AW;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [NP-1:0]         clk_en, ce0_n, ce1, we_n, oe_n;
    logic [NP-1:0][1:0]    lane_n;
    logic [NP-1:0][AW-1:0] addr;
    logic [NP-1:0][17:0]   wdata;
    logic [NP-1:0][17:0]   rdata;
    logic [NP-1:0][1:0]    rvalid;

    logic [17:0] model    [NW];
    logic [1:0]  exp_lane [NP];
    logic [17:0] exp_data [NP];

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    quad_sram #(.PORTS(NP), .ADDR_W(AW), .LANE_W(9), .LANES(2)) u_quad_sram (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_clk_en (clk_en),
        .port_ce0_n  (ce0_n),
        .port_ce1    (ce1),
        .port_we_n   (we_n),
        .port_oe_n   (oe_n),
        .port_lane_n (lane_n),
        .port_addr   (addr),
        .port_wdata  (wdata),
        .port_rdata  (rdata),
        .port_rvalid (rvalid)
    );

    function automatic logic [17:0] pat(input int a, input int p, input int k);
        return 18'(a * 2741 + p * 613 + k * 97 + 5);
    endfunction

    task automatic idle_all();
        for (int p = 0; p < NP; p++) begin
            clk_en[p] = 1'b1; ce0_n[p] = 1'b1; ce1[p] = 1'b0; we_n[p] = 1'b1;
            oe_n[p] = 1'b0; lane_n[p] = 2'b11; addr[p] = '0; wdata[p] = '0;
        end
    endtask

    // kind: 0 deselected, 1 read, 2 write; lanes active high
    task automatic set_port(input int p, input int kind, input int a,
                            input logic [1:0] lanes, input logic [17:0] d);
        ce0_n[p]  = (kind == 0);
        ce1[p]    = (kind != 0);
        we_n[p]   = (kind != 2);
        addr[p]   = AW'(a);
        lane_n[p] = ~lanes;
        wdata[p]  = d;
    endtask

    task automatic step();
        logic [17:0] nxt [NW];
        for (int w = 0; w < NW; w++) nxt[w] = model[w];
        for (int p = 0; p < NP; p++) begin
            if (!rst_n) begin
                exp_lane[p] = '0; exp_data[p] = '0;
            end else if (clk_en[p]) begin
                if (!ce0_n[p] && ce1[p] && we_n[p]) begin
                    exp_lane[p] = ~lane_n[p];
                    exp_data[p] = model[addr[p]];
                end else begin
                    exp_lane[p] = '0;
                end
            end
        end
        if (rst_n) begin
            for (int p = NP - 1; p >= 0; p--) begin
                if (clk_en[p] && !ce0_n[p] && ce1[p] && !we_n[p]) begin
                    for (int l = 0; l < 2; l++)
                        if (!lane_n[p][l]) nxt[addr[p]][l*9 +: 9] = wdata[p][l*9 +: 9];
                end
            end
        end
        @(posedge clk);
        for (int w = 0; w < NW; w++) model[w] = nxt[w];
        @(negedge clk);
    endtask

    task automatic check_ports(input string req);
        for (int p = 0; p < NP; p++) begin
            logic [1:0]  ev;
            logic [17:0] ed;
            ev = exp_lane[p] & {2{~oe_n[p]}};
            ed = '0;
            for (int l = 0; l < 2; l++) if (ev[l]) ed[l*9 +: 9] = exp_data[p][l*9 +: 9];
            n_chk++;
            if (rvalid[p] !== ev || rdata[p] !== ed) begin
                n_err++;
                $display("FAIL %s port %0d: rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
                         req, p, rvalid[p], rdata[p], ev, ed);
            end
        end
    endtask

    initial begin
        rst_n = 1'b0;
        idle_all();
        for (int p = 0; p < NP; p++) begin exp_lane[p] = '0; exp_data[p] = '0; end
        repeat (3) @(negedge clk);
        check_ports("R7 reset state");
        rst_n = 1'b1;
        @(negedge clk);

        // fill every word, all ports writing different words per edge (R2, R9)
        for (int a = 0; a < NW / NP; a++) begin
            for (int p = 0; p < NP; p++) set_port(p, 2, a * NP + p, 2'b11, pat(a * NP + p, 0, 0));
            step();
        end

        // read sweep with rotating lanes and output enables (R3, R4, R9)
        for (int a = 0; a < NW; a++) begin
            for (int p = 0; p < NP; p++) begin
                set_port(p, 1, (a + p * 5) % NW, 2'((a + p) % 4), '0);
                oe_n[p] = ((a + p) % 3 == 0);
            end
            step();
            check_ports("R3 R4 R9 read sweep");
        end
        for (int p = 0; p < NP; p++) oe_n[p] = 1'b0;

        // lane-only writes keep the other lane (R2)
        for (int m = 1; m < 3; m++) begin
            idle_all();
            set_port(2, 2, 6, 2'(m), pat(6, 2, m + 40));
            step();
            idle_all();
            set_port(0, 1, 6, 2'b11, '0);
            step();
            check_ports("R2 lane write");
        end

        // every set of colliding writers on one word (R5)
        for (int m = 1; m < 16; m++) begin
            idle_all();
            for (int p = 0; p < NP; p++) if (m[p]) set_port(p, 2, 9, 2'b11, pat(9, p, m));
            step();
            idle_all();
            set_port(3, 1, 9, 2'b11, '0);
            step();
            check_ports("R5 collision");
        end
        // every per-lane mix of writers (R5)
        for (int lm = 0; lm < 256; lm++) begin
            idle_all();
            for (int p = 0; p < NP; p++) set_port(p, 2, 3, 2'((lm >> (2 * p)) & 3), pat(3, p, lm));
            step();
            idle_all();
            set_port(1, 1, 3, 2'b11, '0);
            step();
            check_ports("R5 lane collision");
        end

        // read on the same edge as a write (R6)
        idle_all();
        set_port(0, 2, 7, 2'b11, pat(7, 0, 77));
        set_port(3, 1, 7, 2'b11, '0);
        step();
        check_ports("R6 old data");
        idle_all();
        set_port(3, 1, 7, 2'b11, '0);
        step();
        check_ports("R6 new data");

        // chip-enable combinations (R1)
        for (int c = 0; c < 4; c++) begin
            idle_all();
            set_port(1, 2, 12, 2'b11, pat(12, 1, c + 20));
            ce0_n[1] = c[0]; ce1[1] = c[1];
            set_port(2, 1, 12, 2'b11, '0);
            ce0_n[2] = c[0]; ce1[2] = c[1];
            step();
            check_ports("R1 select read");
            idle_all();
            set_port(0, 1, 12, 2'b11, '0);
            step();
            check_ports("R1 select write");
        end

        // gated strobe holds and blocks writes (R8)
        idle_all();
        set_port(0, 1, 2, 2'b11, '0);
        step();
        check_ports("R8 before gate");
        set_port(0, 2, 5, 2'b11, pat(5, 0, 99));
        clk_en[0] = 1'b0;
        step();
        check_ports("R8 held");
        clk_en[0] = 1'b1;
        idle_all();
        set_port(1, 1, 5, 2'b11, '0);
        clk_en[0] = 1'b0;
        step();
        check_ports("R8 no write");

        // output enable without a clock (R4)
        idle_all();
        set_port(2, 1, 6, 2'b11, '0);
        step();
        idle_all();
        clk_en[2] = 1'b0;
        #0.5 oe_n[2] = 1'b1;
        #0.5 check_ports("R4 oe off");
        oe_n[2] = 1'b0;
        #0.5 check_ports("R4 oe on");
        @(negedge clk);

        // asynchronous reset in mid-run (R7)
        idle_all();
        set_port(1, 1, 4, 2'b11, '0);
        step();
        check_ports("R7 before reset");
        #0.5 rst_n = 1'b0;
        for (int p = 0; p < NP; p++) begin exp_lane[p] = '0; exp_data[p] = '0; end
        #0.5 check_ports("R7 async clear");
        @(negedge clk);
        idle_all();
        set_port(0, 2, 4, 2'b11, pat(4, 0, 123));
        step();
        check_ports("R7 during reset");
        rst_n = 1'b1;
        idle_all();
        set_port(1, 1, 4, 2'b11, '0);
        step();
        check_ports("R7 write blocked");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule